// File: doc/BRIEF.md
# Address Translation Map Cache

This block turns a virtual page number into a real page number and a 4-bit flag field, on behalf of one address-space identifier (ASID). It has a 256-slot direct-mapped table and eight configuration registers. Three of the register pairs are mask/pattern region selectors. The subset region marks which pages this block is responsible for. The bypass region sends pages through a fixed relocation and never reads the table. The shared region makes every ASID look up the page as ASID 0.

Three ports feed the block. The configuration port reads and writes the registers by index. The entry-write port installs a translation under the ASID that is currently held in the configuration registers. The lookup port takes a page and a requester ASID, and one cycle later returns a strobe with four results: ignored, miss-error, real page and flags. Refilling a missed entry is left to the surrounding logic.

Top module: `xlat_map_cache`

## Requirements
- R1: During and after reset, `rsp_valid` and `ew_ack` are low and every configuration register reads 0. After every reset, all table slots are invalid, so a table lookup misses until an entry is written.
- R2: The configuration registers are indexed as follows: 0 = current ASID (16 bits, read back zero-extended), 1 = subset mask, 2 = subset pattern, 3 = bypass mask, 4 = bypass pattern, 5 = bypass base, 6 = shared mask, 7 = shared pattern. Read data follows `cfg_addr` combinationally. Indices 8 to 15 read 0, and writes to them change nothing.
- R3: A lookup request produces exactly one `rsp_valid` pulse, in the next cycle.
- R4: A page is in a region when (page AND mask) equals (pattern AND mask). A lookup whose page is outside the subset returns ignored=1, miss=0, real page 0 and flags 0.
- R5: For a page in the subset, a requester ASID of 0xFFFF returns the virtual page unchanged with flags 12.
- R6: For a page in the bypass region with an ASID other than 0xFFFF, the result is (bypass base AND bypass mask) OR (page AND NOT bypass mask), with flags 12.
- R7: Every other lookup reads the slot at index = bits[7:0] XOR bits[15:8] of (ASID zero-extended XOR page). If the slot is valid and its stored ASID equals the effective ASID, the lookup returns the stored real page and flags. Otherwise it returns miss=1, real page 0 and flags 0.
- R8: A page in the shared region is looked up with effective ASID 0, whatever the requester's ASID.
- R9: An entry write is acknowledged one cycle later on `ew_ack`.
  - A page outside the subset gives `ew_ignored`=1 and writes nothing.
  - A write while the ASID register holds 0xFFFF, or for a bypass page, is dropped with `ew_ignored`=0.
  - Any other write fills the slot hashed from the ASID register and the page, storing that ASID, the real page, the flags and `ew_entry_valid`.
- R10: A lookup in the same cycle as an entry write or a register write uses the table and registers as they were before that write.
- R11: The checks are made in this order: subset first, then ASID 0xFFFF, then bypass, then the table.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| ew_req | input | 1 | Entry write request |
| ew_vp | input | 32 | Entry virtual page |
| ew_rpage | input | 32 | Entry real page |
| ew_flags | input | 4 | Entry flags |
| ew_entry_valid | input | 1 | Valid bit to store in the entry |
| ew_ack | output | 1 | Entry write done (one cycle after request) |
| ew_ignored | output | 1 | Entry write page was outside the subset |
| lk_req | input | 1 | Lookup request |
| lk_vp | input | 32 | Lookup virtual page |
| lk_asid | input | 16 | Requester ASID |
| rsp_valid | output | 1 | Lookup result strobe |
| rsp_ignored | output | 1 | Page outside the subset |
| rsp_miss | output | 1 | Table miss error |
| rsp_rpage | output | 32 | Real page |
| rsp_flags | output | 4 | Flags |

## Verification
An entry write can land in the same cycle as a lookup of the same slot. The bench raises both requests on one clock edge with a new real page for an entry that already hits. The lookup must return the old translation, and a second lookup must return the new one. A register write is also made to coincide with a lookup: moving the subset pattern must leave that lookup's hit intact, and only the following lookup may come back ignored.

// File: rtl/xmc_pkg.sv
// Shared widths, register indices and types for the address translation map cache.
// Assumes 32-bit pages and 16-bit ASIDs; 0xFFFF is the no-translation ASID.
package xmc_pkg;
    localparam int VPN_W  = 32;
    localparam int ASID_W = 16;
    localparam int FLAG_W = 4;
    localparam int CFG_AW = 4;
    localparam int NREG   = 8;

    typedef enum logic [CFG_AW-1:0] {
        RI_ASID     = 4'd0,
        RI_SUB_MASK = 4'd1,
        RI_SUB_PAT  = 4'd2,
        RI_BYP_MASK = 4'd3,
        RI_BYP_PAT  = 4'd4,
        RI_BYP_BASE = 4'd5,
        RI_SHR_MASK = 4'd6,
        RI_SHR_PAT  = 4'd7
    } reg_idx_e;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  sub_mask;
        logic [VPN_W-1:0]  sub_pat;
        logic [VPN_W-1:0]  byp_mask;
        logic [VPN_W-1:0]  byp_pat;
        logic [VPN_W-1:0]  byp_base;
        logic [VPN_W-1:0]  shr_mask;
        logic [VPN_W-1:0]  shr_pat;
    } cfg_t;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  rpage;
        logic [FLAG_W-1:0] flags;
    } entry_t;
endpackage

// File: rtl/xmc_cfg_regs.sv
// Configuration register file: NREG word registers written by index in one cycle,
// read combinationally. Assumes index values of NREG and above are unmapped.
module xmc_cfg_regs
    import xmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [VPN_W-1:0]  wdata,
    output logic [VPN_W-1:0]  rdata,
    output cfg_t              cfg
);
    logic [VPN_W-1:0] regs [NREG];

    // Register storage with synchronous clear; unmapped indices are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (32'(addr) < NREG)) begin
            if (addr == RI_ASID)
                regs[addr[2:0]] <= {{(VPN_W-ASID_W){1'b0}}, wdata[ASID_W-1:0]};
            else
                regs[addr[2:0]] <= wdata;
        end
    end

    // Read mux; unmapped indices read zero.
    always_comb begin
        rdata = (32'(addr) < NREG) ? regs[addr[2:0]] : '0;
    end

    // Present the registers as a named structure.
    always_comb begin
        cfg.asid     = regs[RI_ASID][ASID_W-1:0];
        cfg.sub_mask = regs[RI_SUB_MASK];
        cfg.sub_pat  = regs[RI_SUB_PAT];
        cfg.byp_mask = regs[RI_BYP_MASK];
        cfg.byp_pat  = regs[RI_BYP_PAT];
        cfg.byp_base = regs[RI_BYP_BASE];
        cfg.shr_mask = regs[RI_SHR_MASK];
        cfg.shr_pat  = regs[RI_SHR_PAT];
    end
endmodule

// File: rtl/xmc_region_match.sv
// Mask/pattern region test: a page is inside when its masked bits equal the masked pattern.
// Purely combinational; assumes mask bits of 0 mean "don't care".
module xmc_region_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] page,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pat,
    output logic         hit
);
    // Compare only the bits the mask selects.
    always_comb hit = ((page & mask) == (pat & mask));
endmodule

// File: rtl/xmc_table.sv
// Direct-mapped translation storage: one write port, one combinational read port.
// Valid bits clear on reset; entry contents are not reset. A read in the
// cycle of a write to the same slot sees the old contents.
module xmc_table
    import xmc_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic             wvalid,
    input  entry_t           wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic             rvalid,
    output entry_t           rdata
);
    logic   vld [DEPTH];
    entry_t mem [DEPTH];

    // Valid bits: cleared by reset, set or cleared by each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) vld[i] <= 1'b0;
        end else if (we) begin
            vld[waddr] <= wvalid;
        end
    end

    // Entry payload storage.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read of the indexed slot.
    always_comb begin
        rvalid = vld[raddr];
        rdata  = mem[raddr];
    end
endmodule

// File: rtl/xlat_map_cache.sv
// Address translation map cache top. Lookups resolve through subset, no-translation ASID,
// bypass relocation, shared-region ASID substitution and a hashed table, with a one-cycle
// registered response. Entry writes use the ASID register. Assumes one lookup per cycle.
module xlat_map_cache
    import xmc_pkg::*;
#(
    parameter int            IDX_W     = 8,
    parameter logic [FLAG_W-1:0] DEF_FLAGS = 4'd12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [VPN_W-1:0]  cfg_wdata,
    output logic [VPN_W-1:0]  cfg_rdata,
    input  logic              ew_req,
    input  logic [VPN_W-1:0]  ew_vp,
    input  logic [VPN_W-1:0]  ew_rpage,
    input  logic [FLAG_W-1:0] ew_flags,
    input  logic              ew_entry_valid,
    output logic              ew_ack,
    output logic              ew_ignored,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vp,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rsp_valid,
    output logic              rsp_ignored,
    output logic              rsp_miss,
    output logic [VPN_W-1:0]  rsp_rpage,
    output logic [FLAG_W-1:0] rsp_flags
);
    localparam logic [ASID_W-1:0] NO_XLAT = '1;

    // Fold (asid ^ page) into an IDX_W-bit slot index.
    function automatic logic [IDX_W-1:0] slot_of(logic [ASID_W-1:0] id, logic [VPN_W-1:0] pg);
        logic [VPN_W-1:0] w;
        w = pg ^ {{(VPN_W-ASID_W){1'b0}}, id};
        return w[IDX_W-1:0] ^ w[2*IDX_W-1:IDX_W];
    endfunction

    cfg_t cfg;

    xmc_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Region tests for both page sources: lane 0 = lookup, lane 1 = entry write.
    logic [VPN_W-1:0] lane_pg  [2];
    logic             sub_hit  [2];
    logic             byp_hit  [2];
    logic             shr_hit;

    always_comb begin
        lane_pg[0] = lk_vp;
        lane_pg[1] = ew_vp;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        xmc_region_match #(.W(VPN_W)) u_sub (
            .page (lane_pg[g]), .mask (cfg.sub_mask), .pat (cfg.sub_pat), .hit (sub_hit[g]));
        xmc_region_match #(.W(VPN_W)) u_byp (
            .page (lane_pg[g]), .mask (cfg.byp_mask), .pat (cfg.byp_pat), .hit (byp_hit[g]));
    end

    xmc_region_match #(.W(VPN_W)) u_shr (
        .page (lk_vp), .mask (cfg.shr_mask), .pat (cfg.shr_pat), .hit (shr_hit));

    // Entry-write decision: only in-subset, translated, non-bypass pages reach the table.
    logic             tbl_we;
    logic [IDX_W-1:0] tbl_waddr;
    entry_t           tbl_wdata;

    always_comb begin
        tbl_we    = ew_req && sub_hit[1] && (cfg.asid != NO_XLAT) && !byp_hit[1];
        tbl_waddr = slot_of(cfg.asid, ew_vp);
        tbl_wdata = '{asid: cfg.asid, rpage: ew_rpage, flags: ew_flags};
    end

    // Lookup table read using the effective ASID.
    logic [ASID_W-1:0] eff_asid;
    logic [IDX_W-1:0]  tbl_raddr;
    logic              slot_vld;
    entry_t            slot;

    always_comb begin
        eff_asid  = shr_hit ? '0 : lk_asid;
        tbl_raddr = slot_of(eff_asid, lk_vp);
    end

    xmc_table #(.IDX_W(IDX_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (tbl_we),
        .waddr  (tbl_waddr),
        .wvalid (ew_entry_valid),
        .wdata  (tbl_wdata),
        .raddr  (tbl_raddr),
        .rvalid (slot_vld),
        .rdata  (slot)
    );

    // Lookup resolution in priority order.
    logic              nx_ign, nx_miss;
    logic [VPN_W-1:0]  nx_rp;
    logic [FLAG_W-1:0] nx_fl;

    always_comb begin
        nx_ign  = 1'b0;
        nx_miss = 1'b0;
        nx_rp   = '0;
        nx_fl   = '0;
        if (!sub_hit[0]) begin
            nx_ign = 1'b1;
        end else if (lk_asid == NO_XLAT) begin
            nx_rp = lk_vp;
            nx_fl = DEF_FLAGS;
        end else if (byp_hit[0]) begin
            nx_rp = (cfg.byp_base & cfg.byp_mask) | (lk_vp & ~cfg.byp_mask);
            nx_fl = DEF_FLAGS;
        end else if (slot_vld && (slot.asid == eff_asid)) begin
            nx_rp = slot.rpage;
            nx_fl = slot.flags;
        end else begin
            nx_miss = 1'b1;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_ignored <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_rpage   <= '0;
            rsp_flags   <= '0;
        end else begin
            rsp_valid   <= lk_req;
            rsp_ignored <= lk_req && nx_ign;
            rsp_miss    <= lk_req && nx_miss;
            rsp_rpage   <= lk_req ? nx_rp : '0;
            rsp_flags   <= lk_req ? nx_fl : '0;
        end
    end

    // Registered entry-write acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ew_ack     <= 1'b0;
            ew_ignored <= 1'b0;
        end else begin
            ew_ack     <= ew_req;
            ew_ignored <= ew_req && !sub_hit[1];
        end
    end
endmodule

// File: rtl/xmc_checker.sv
// Protocol and result-shape assertions for xlat_map_cache, attached by bind.
module xmc_checker
    import xmc_pkg::*;
#(
    parameter logic [FLAG_W-1:0] DEF_FLAGS = 4'd12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ew_req,
    input logic              ew_ack,
    input logic              lk_req,
    input logic [VPN_W-1:0]  lk_vp,
    input logic [ASID_W-1:0] lk_asid,
    input logic              rsp_valid,
    input logic              rsp_ignored,
    input logic              rsp_miss,
    input logic [VPN_W-1:0]  rsp_rpage,
    input logic [FLAG_W-1:0] rsp_flags
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R3
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid); // R3
    AST_IGN_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_ignored && rsp_miss)); // R4
    AST_FAIL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_ignored || rsp_miss)) |-> (rsp_rpage == '0 && rsp_flags == '0)); // R7
    AST_NOXLAT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_asid == '1) |=>
            (rsp_ignored || (!rsp_miss && rsp_rpage == $past(lk_vp) && rsp_flags == DEF_FLAGS))); // R5
    AST_EW_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ew_req |=> ew_ack); // R9
endmodule

bind xlat_map_cache xmc_checker #(.DEF_FLAGS(DEF_FLAGS)) u_xmc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ew_req      (ew_req),
    .ew_ack      (ew_ack),
    .lk_req      (lk_req),
    .lk_vp       (lk_vp),
    .lk_asid     (lk_asid),
    .rsp_valid   (rsp_valid),
    .rsp_ignored (rsp_ignored),
    .rsp_miss    (rsp_miss),
    .rsp_rpage   (rsp_rpage),
    .rsp_flags   (rsp_flags)
);

// File: tb/xlat_map_cache_bench.sv
`timescale 1ns/1ps
module xlat_map_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ew_req = 1'b0;
    logic [31:0] ew_vp = '0, ew_rpage = '0;
    logic [3:0]  ew_flags = '0;
    logic        ew_entry_valid = 1'b0;
    logic        ew_ack, ew_ignored;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vp = '0;
    logic [15:0] lk_asid = '0;
    logic        rsp_valid, rsp_ignored, rsp_miss;
    logic [31:0] rsp_rpage;
    logic [3:0]  rsp_flags;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xlat_map_cache u_xlat_map_cache (.*);

    typedef struct packed {
        logic [31:0] vp;
        logic [15:0] asid;
        logic        ign;
        logic        miss;
        logic [31:0] rp;
        logic [3:0]  fl;
    } vec_t;

    // Expected results for the configuration and entries installed below.
    localparam vec_t VEC [12] = '{
        '{32'h2000_0034, 16'h0005, 1'b1, 1'b0, 32'h0,         4'd0},  // R4 outside subset
        '{32'h1000_0034, 16'hFFFF, 1'b0, 1'b0, 32'h1000_0034, 4'd12}, // R5 identity
        '{32'h1ABC_1234, 16'h0005, 1'b0, 1'b0, 32'h7777_1234, 4'd12}, // R6 relocation
        '{32'h1000_0034, 16'h0005, 1'b0, 1'b0, 32'hAAAA_0001, 4'd3},  // R7 hit
        '{32'h1000_0034, 16'h0006, 1'b0, 1'b1, 32'h0,         4'd0},  // R7 empty slot
        '{32'h1000_0135, 16'h0104, 1'b0, 1'b1, 32'h0,         4'd0},  // R7 same slot, other ASID
        '{32'h1200_0100, 16'h0005, 1'b0, 1'b0, 32'hBBBB_0002, 4'd5},  // R8 shared
        '{32'h1200_0100, 16'h0009, 1'b0, 1'b0, 32'hBBBB_0002, 4'd5},  // R8 shared, other ASID
        '{32'h1000_0200, 16'h0005, 1'b0, 1'b1, 32'h0,         4'd0},  // R9 stored invalid
        '{32'h2ABC_0000, 16'hFFFF, 1'b1, 1'b0, 32'h0,         4'd0},  // R11 subset first
        '{32'h1ABC_0001, 16'hFFFF, 1'b0, 1'b0, 32'h1ABC_0001, 4'd12}, // R11 identity before bypass
        '{32'h1000_0034, 16'h0000, 1'b0, 1'b1, 32'h0,         4'd0}   // R7 ASID 0 miss
    };
    localparam string VTAG [12] = '{"R4", "R5", "R6", "R7", "R7", "R7",
                                    "R8", "R8", "R9", "R11", "R11", "R7"};

    // Count one check and report a mismatch.
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic ent_wr(input logic [31:0] vp, input logic [31:0] rp, input logic [3:0] fl,
                          input logic vb, input logic exp_ign, input string tag);
        @(negedge clk);
        ew_req = 1'b1; ew_vp = vp; ew_rpage = rp; ew_flags = fl; ew_entry_valid = vb;
        @(negedge clk);
        ew_req = 1'b0;
        check(ew_ack && ew_ignored == exp_ign, tag, {62'b0, ew_ack, ew_ignored}, {62'b0, 1'b1, exp_ign});
    endtask

    task automatic look(input logic [31:0] vp, input logic [15:0] id, input logic ei, input logic em,
                        input logic [31:0] erp, input logic [3:0] efl, input string tag);
        logic [63:0] act, exp;
        @(negedge clk);
        lk_req = 1'b1; lk_vp = vp; lk_asid = id;
        @(negedge clk);
        lk_req = 1'b0;
        act = {25'b0, rsp_valid, rsp_ignored, rsp_miss, rsp_rpage, rsp_flags};
        exp = {25'b0, 1'b1, ei, em, erp, efl};
        check(act == exp, tag, act, exp);
    endtask

    task automatic configure();
        cfg_wr(4'd1, 32'hF000_0000);
        cfg_wr(4'd2, 32'h1000_0000);
        cfg_wr(4'd3, 32'hFFFF_0000);
        cfg_wr(4'd4, 32'h1ABC_0000);
        cfg_wr(4'd5, 32'h7777_0000);
        cfg_wr(4'd6, 32'hFFF0_0000);
        cfg_wr(4'd7, 32'h1200_0000);
        cfg_wr(4'd0, 32'h0000_0005);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!rsp_valid && !ew_ack, "R1", {62'b0, rsp_valid, ew_ack}, 64'b0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < 8; i++) cfg_chk(4'(i), 32'h0, "R1");

        configure();
        // R1: nothing written yet, so the table lookup misses
        look(32'h1000_0034, 16'h0005, 1'b0, 1'b1, 32'h0, 4'd0, "R1");

        // Install entries: shared one under ASID 0, then two under ASID 5
        cfg_wr(4'd0, 32'h0000_0000);
        ent_wr(32'h1200_0100, 32'hBBBB_0002, 4'd5, 1'b1, 1'b0, "R9");
        cfg_wr(4'd0, 32'h0000_0005);
        ent_wr(32'h1000_0034, 32'hAAAA_0001, 4'd3, 1'b1, 1'b0, "R9");
        ent_wr(32'h1000_0200, 32'h0000_00CC, 4'd7, 1'b0, 1'b0, "R9");
        ent_wr(32'h2000_0000, 32'h0000_00EE, 4'd1, 1'b1, 1'b1, "R9");

        for (int i = 0; i < 12; i++)
            look(VEC[i].vp, VEC[i].asid, VEC[i].ign, VEC[i].miss, VEC[i].rp, VEC[i].fl, VTAG[i]);

        // R9: dropped writes aimed at slot 0x31 must leave the existing entry intact
        cfg_wr(4'd0, 32'h0000_FFFF);
        ent_wr(32'h1000_FFCE, 32'hDEAD_0000, 4'd1, 1'b1, 1'b0, "R9");
        cfg_wr(4'd0, 32'h0000_0005);
        ent_wr(32'h1ABC_0034, 32'hDEAD_0001, 4'd2, 1'b1, 1'b0, "R9");
        look(32'h1000_0034, 16'h0005, 1'b0, 1'b0, 32'hAAAA_0001, 4'd3, "R9");

        // R2: register map, ASID width and unmapped indices
        cfg_wr(4'd0, 32'hABCD_0005);
        cfg_chk(4'd0, 32'h0000_0005, "R2");
        cfg_chk(4'd5, 32'h7777_0000, "R2");
        cfg_wr(4'd9, 32'h1234_5678);
        cfg_chk(4'd9, 32'h0, "R2");
        cfg_chk(4'd1, 32'hF000_0000, "R2");

        // R10: entry write and lookup of the same slot in one cycle
        @(negedge clk);
        lk_req = 1'b1; lk_vp = 32'h1000_0034; lk_asid = 16'h0005;
        ew_req = 1'b1; ew_vp = 32'h1000_0034; ew_rpage = 32'h1111_2222; ew_flags = 4'd9; ew_entry_valid = 1'b1;
        @(negedge clk);
        lk_req = 1'b0; ew_req = 1'b0;
        check(rsp_valid && rsp_rpage == 32'hAAAA_0001 && rsp_flags == 4'd3, "R10",
              {27'b0, rsp_valid, rsp_rpage, rsp_flags}, {27'b0, 1'b1, 32'hAAAA_0001, 4'd3});
        look(32'h1000_0034, 16'h0005, 1'b0, 1'b0, 32'h1111_2222, 4'd9, "R10");

        // R10: register write and lookup in one cycle
        @(negedge clk);
        lk_req = 1'b1; lk_vp = 32'h1000_0034; lk_asid = 16'h0005;
        cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 32'h3000_0000;
        @(negedge clk);
        lk_req = 1'b0; cfg_we = 1'b0;
        check(rsp_valid && !rsp_ignored && rsp_rpage == 32'h1111_2222, "R10",
              {30'b0, rsp_valid, rsp_ignored, rsp_rpage}, {30'b0, 1'b1, 1'b0, 32'h1111_2222});
        look(32'h1000_0034, 16'h0005, 1'b1, 1'b0, 32'h0, 4'd0, "R10");

        // R1: a second reset invalidates the table
        do_reset();
        configure();
        look(32'h1000_0034, 16'h0005, 1'b0, 1'b1, 32'h0, 4'd0, "R1");
        look(32'h1200_0100, 16'h0005, 1'b0, 1'b1, 32'h0, 4'd0, "R1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule